// File: doc/BRIEF.md
# Element-width polymorphic register file

This block holds 128 integer registers of 64 bits each and treats the whole set as one flat array of 1024 bytes. An access names a starting register, an element index and an element width (8, 16, 32 or 64 bits). The byte at which the element starts is found by scaling the index by the element size and adding the offset of the named register. Elements of one width therefore pack tightly, and an index too large for one register carries on into the registers that follow.

There is one combinational read port and one write port that commits on the rising clock edge. Neither port wraps around. If any byte of an element would fall past the last physical byte, that port raises a fault flag. A faulting read returns zero, and a faulting write changes nothing. A synchronous reset clears every register.

Top module: `elem_regfile`

## Requirements
- R1: After a synchronous reset (rst high at a rising edge), every non-faulting read returns zero until a write lands.
- R2: A 64-bit write (width code 3) to register r, index 0, is returned unchanged by a 64-bit read of register r, index 0, in the cycle after the write edge.
- R3: Width code 0 selects 8-bit elements. Byte element i of register r is the byte at address r*8+i. A 64-bit read assembles the bytes little-endian, so the lowest address goes to bits 7:0. A read narrower than 64 bits returns the element zero-extended to 64 bits.
- R4: Width codes 1 and 2 select 16-bit and 32-bit elements at byte address r*8 + index*2 and r*8 + index*4. An element whose bytes lie past register r's eight bytes continues into register r+1 and the registers after it.
- R5: A write of an element narrower than 64 bits changes only the bytes it covers, taken from the low bits of wr_data. All other bytes keep their values.
- R6: A port faults when address + element size exceeds 1024 bytes, and only then. Examples: register 127 accepts byte index 7 but not 8, and register 0 accepts byte index 1023.
- R7: While the read port faults, rd_data is zero in the same cycle.
- R8: A faulting write (wr_en high and wr_fault high) leaves every register unchanged. In particular it does not wrap around to register 0.
- R9: When a read and a write touch the same bytes in one cycle, the read returns the contents from before the write. The new value is visible from the next cycle on.
- R10: Asserting reset after writes clears every register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset, clears all registers |
| wr_en | input | 1 | Write request |
| wr_width | input | 2 | Write element width: 0=8, 1=16, 2=32, 3=64 bits |
| wr_reg | input | 7 | Write starting register number |
| wr_idx | input | 10 | Write element index |
| wr_data | input | 64 | Write element, held in the low bits |
| wr_fault | output | 1 | Write out of range (only while wr_en is high) |
| rd_width | input | 2 | Read element width: 0=8, 1=16, 2=32, 3=64 bits |
| rd_reg | input | 7 | Read starting register number |
| rd_idx | input | 10 | Read element index |
| rd_data | output | 64 | Read element, zero-extended |
| rd_fault | output | 1 | Read out of range |

## Verification
A read and a write can fall in the same cycle, and they may overlap on the same bytes. The bench provokes this by writing one value to a register, then in the next cycle writing a second value while it reads that same register. It expects the first value in that cycle and the second value in the cycle after. The same cycle-by-cycle model also judges cases where a faulting write sits beside a valid read, confirming that the fault neither blocks the read nor alters storage.

// File: rtl/ewrf_pkg.sv
package ewrf_pkg;
  typedef enum logic [1:0] {
    EW_B8  = 2'd0,
    EW_B16 = 2'd1,
    EW_B32 = 2'd2,
    EW_B64 = 2'd3
  } ew_sel_e;
endpackage

// File: rtl/ewrf_addr_gen.sv
module ewrf_addr_gen #(
  parameter int NUM_REGS  = 128,
  parameter int REG_BYTES = 8,
  parameter int IDX_W     = 10,
  localparam int TOTAL    = NUM_REGS * REG_BYTES,
  localparam int ADDR_W   = $clog2(TOTAL),
  localparam int REG_W    = $clog2(NUM_REGS),
  localparam int LANE_W   = $clog2(REG_BYTES)
) (
  input  ewrf_pkg::ew_sel_e     wsel,
  input  logic [REG_W-1:0]      reg_num,
  input  logic [IDX_W-1:0]      idx,
  output logic [ADDR_W-1:0]     addr,
  output logic [REG_BYTES-1:0]  lane_en,
  output logic                  fault
);
  localparam int CALC_W = IDX_W + REG_W + LANE_W + 2;

  logic [CALC_W-1:0] base, span, nbytes, start, last;

  always_comb begin
    base   = CALC_W'(reg_num) << LANE_W;
    span   = CALC_W'(idx) << wsel;
    nbytes = CALC_W'(1) << wsel;
    start  = base + span;
    last   = start + nbytes;
    fault  = last > CALC_W'(TOTAL);
    addr   = start[ADDR_W-1:0];
  end

  for (genvar k = 0; k < REG_BYTES; k++) begin : g_lane
    assign lane_en[k] = CALC_W'(k) < nbytes;
  end
endmodule

// File: rtl/ewrf_byte_store.sv
module ewrf_byte_store #(
  parameter int NUM_REGS  = 128,
  parameter int REG_BYTES = 8,
  localparam int TOTAL    = NUM_REGS * REG_BYTES,
  localparam int ADDR_W   = $clog2(TOTAL),
  localparam int DATA_W   = REG_BYTES * 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    waddr,
  input  logic [REG_BYTES-1:0] wlane,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [ADDR_W-1:0]    raddr,
  output logic [DATA_W-1:0]    rbytes
);
  logic [7:0] mem [TOTAL];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TOTAL; i++) mem[i] <= 8'h00;
    end else if (we) begin
      for (int k = 0; k < REG_BYTES; k++) begin
        if (wlane[k]) mem[waddr + ADDR_W'(k)] <= wdata[8*k +: 8];
      end
    end
  end

  for (genvar k = 0; k < REG_BYTES; k++) begin : g_rd
    assign rbytes[8*k +: 8] = mem[raddr + ADDR_W'(k)];
  end
endmodule

// File: rtl/elem_regfile.sv
module elem_regfile #(
  parameter int NUM_REGS  = 128,
  parameter int REG_BYTES = 8,
  parameter int IDX_W     = 10,
  localparam int TOTAL    = NUM_REGS * REG_BYTES,
  localparam int ADDR_W   = $clog2(TOTAL),
  localparam int REG_W    = $clog2(NUM_REGS),
  localparam int DATA_W   = REG_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_width,
  input  logic [REG_W-1:0]  wr_reg,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_fault,
  input  logic [1:0]        rd_width,
  input  logic [REG_W-1:0]  rd_reg,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_fault
);
  import ewrf_pkg::*;

  logic [ADDR_W-1:0]    w_addr, r_addr;
  logic [REG_BYTES-1:0] w_lane, r_lane;
  logic                 w_oor, r_oor;
  logic [DATA_W-1:0]    r_raw;

  ewrf_addr_gen #(.NUM_REGS(NUM_REGS), .REG_BYTES(REG_BYTES), .IDX_W(IDX_W)) u_wgen (
    .wsel(ew_sel_e'(wr_width)), .reg_num(wr_reg), .idx(wr_idx),
    .addr(w_addr), .lane_en(w_lane), .fault(w_oor));

  ewrf_addr_gen #(.NUM_REGS(NUM_REGS), .REG_BYTES(REG_BYTES), .IDX_W(IDX_W)) u_rgen (
    .wsel(ew_sel_e'(rd_width)), .reg_num(rd_reg), .idx(rd_idx),
    .addr(r_addr), .lane_en(r_lane), .fault(r_oor));

  assign wr_fault = wr_en & w_oor;
  assign rd_fault = r_oor;

  ewrf_byte_store #(.NUM_REGS(NUM_REGS), .REG_BYTES(REG_BYTES)) u_store (
    .clk(clk), .rst(rst), .we(wr_en & ~w_oor), .waddr(w_addr), .wlane(w_lane),
    .wdata(wr_data), .raddr(r_addr), .rbytes(r_raw));

  for (genvar k = 0; k < REG_BYTES; k++) begin : g_mask
    assign rd_data[8*k +: 8] = (r_lane[k] && !r_oor) ? r_raw[8*k +: 8] : 8'h00;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !rd_fault) |-> rd_data == '0);

  // R2
  readback_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && wr_en && !wr_fault && wr_width == 2'd3) && rd_width == 2'd3 &&
     rd_reg == $past(wr_reg) && rd_idx == $past(wr_idx)) |-> rd_data == $past(wr_data));

  // R3
  zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_fault && rd_width == 2'd0) |-> rd_data[DATA_W-1:8] == '0);

  // R6
  last_reg_ok_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_reg == REG_W'(NUM_REGS-1) && rd_idx == '0) |-> !rd_fault);

  // R6
  last_reg_wide_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_reg == REG_W'(NUM_REGS-1) && rd_width == 2'd3 && rd_idx != '0) |-> rd_fault);

  // R7
  fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_fault |-> rd_data == '0);
endmodule

// File: tb/elem_regfile_tb_top.sv
module elem_regfile_tb_top;
  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_width = '0, rd_width = '0;
  logic [6:0] wr_reg = '0, rd_reg = '0;
  logic [9:0] wr_idx = '0, rd_idx = '0;
  logic [63:0] wr_data = '0, rd_data;
  logic wr_fault, rd_fault;

  int checks = 0, fails = 0;
  logic [7:0] model [1024];

  always #5 clk = ~clk;

  elem_regfile dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_width(wr_width), .wr_reg(wr_reg),
    .wr_idx(wr_idx), .wr_data(wr_data), .wr_fault(wr_fault), .rd_width(rd_width),
    .rd_reg(rd_reg), .rd_idx(rd_idx), .rd_data(rd_data), .rd_fault(rd_fault));

  function automatic void calc(input int w, input int r, input int i,
                               output int a, output int n, output bit f);
    n = 1 << w;
    a = r * 8 + i * n;
    f = (a + n) > 1024;
  endfunction

  task automatic step(input string tag, input bit we, input int ww, input int wreg,
                      input int widx, input logic [63:0] wd,
                      input int rw, input int rreg, input int ridx);
    int ra, rn, wa, wn;
    bit rf, wf;
    logic [63:0] exp;
    wr_en = we; wr_width = 2'(ww); wr_reg = 7'(wreg); wr_idx = 10'(widx); wr_data = wd;
    rd_width = 2'(rw); rd_reg = 7'(rreg); rd_idx = 10'(ridx);
    calc(rw, rreg, ridx, ra, rn, rf);
    calc(ww, wreg, widx, wa, wn, wf);
    exp = '0;
    if (!rf) for (int k = 0; k < rn; k++) exp[8*k +: 8] = model[ra + k];
    @(negedge clk);
    checks++;
    if (rd_data !== exp || rd_fault !== rf || wr_fault !== (we && wf)) begin
      fails++;
      $display("FAIL %s rd_data=%h exp=%h rd_fault=%b exp=%b wr_fault=%b exp=%b",
               tag, rd_data, exp, rd_fault, rf, wr_fault, we && wf);
    end
    @(posedge clk);
    if (we && !wf) for (int k = 0; k < wn; k++) model[wa + k] = wd[8*k +: 8];
    #1;
  endtask

  task automatic do_reset();
    wr_en = 1'b0;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    for (int i = 0; i < 1024; i++) model[i] = 8'h00;
    #1 rst = 1'b0;
  endtask

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state
    step("R1", 0, 0, 0, 0, 0, 3, 0, 0);
    step("R1", 0, 0, 0, 0, 0, 3, 127, 0);
    step("R1", 0, 0, 0, 0, 0, 0, 64, 5);
    // R2: full-width write and readback
    step("R2", 1, 3, 5, 0, 64'h0123_4567_89AB_CDEF, 3, 5, 0);
    step("R2", 0, 0, 0, 0, 0, 3, 5, 0);
    // R3: byte packing, little-endian assembly, zero extension
    for (int i = 0; i < 8; i++) step("R3", 1, 0, 10, i, 64'(8'h11 + i), 0, 5, i);
    step("R3", 0, 0, 0, 0, 0, 3, 10, 0);
    step("R3", 0, 0, 0, 0, 0, 0, 10, 3);
    step("R3", 0, 0, 0, 0, 0, 0, 5, 9);
    // R4: 16/32-bit elements spilling into following registers
    step("R4", 1, 1, 12, 5, 64'hBEEF, 3, 13, 0);
    step("R4", 0, 0, 0, 0, 0, 3, 13, 0);
    step("R4", 1, 2, 20, 3, 64'hCAFE_F00D, 1, 12, 5);
    step("R4", 0, 0, 0, 0, 0, 3, 21, 0);
    step("R4", 0, 0, 0, 0, 0, 2, 20, 3);
    step("R4", 1, 2, 0, 200, 64'h1234_5678, 3, 100, 0);
    step("R4", 0, 0, 0, 0, 0, 3, 100, 0);
    // R5: narrow writes touch only their bytes
    step("R5", 1, 3, 30, 0, 64'hFFFF_FFFF_FFFF_FFFF, 3, 30, 0);
    step("R5", 1, 0, 30, 2, 64'hAAAA_AAAA_AAAA_AA00, 3, 30, 0);
    step("R5", 1, 1, 30, 3, 64'h5555_5555_5555_1234, 3, 30, 0);
    step("R5", 0, 0, 0, 0, 0, 3, 30, 0);
    // R6 R7: range boundaries, faulting reads return zero
    step("R6", 0, 0, 0, 0, 0, 0, 127, 7);
    step("R6 R7", 0, 0, 0, 0, 0, 0, 127, 8);
    step("R6", 0, 0, 0, 0, 0, 1, 127, 3);
    step("R6 R7", 0, 0, 0, 0, 0, 1, 127, 4);
    step("R6", 0, 0, 0, 0, 0, 3, 126, 1);
    step("R6 R7", 0, 0, 0, 0, 0, 3, 126, 2);
    step("R6", 0, 0, 0, 0, 0, 2, 0, 255);
    step("R6 R7", 0, 0, 0, 0, 0, 2, 0, 256);
    step("R6", 0, 0, 0, 0, 0, 0, 0, 1023);
    // R8: faulting writes change nothing and do not wrap
    step("R8", 1, 3, 127, 0, 64'hDEAD_BEEF_0BAD_F00D, 3, 127, 0);
    step("R8", 1, 3, 127, 1, 64'h7777_7777_7777_7777, 3, 127, 0);
    step("R8", 1, 1, 0, 1023, 64'h9999, 3, 0, 0);
    step("R8", 1, 2, 127, 2, 64'h4444_4444, 3, 127, 0);
    step("R8", 0, 0, 0, 0, 0, 3, 127, 0);
    step("R8", 0, 0, 0, 0, 0, 3, 0, 0);
    // R9: read and write on the same bytes in one cycle
    step("R9", 1, 3, 40, 0, 64'hAAAA_0000_BBBB_1111, 3, 40, 0);
    step("R9", 1, 3, 40, 0, 64'h5A5A_5A5A_C3C3_C3C3, 3, 40, 0);
    step("R9", 1, 0, 40, 0, 64'h00, 3, 40, 0);
    step("R9", 0, 0, 0, 0, 0, 3, 40, 0);
    // R10: reset after writes clears the file
    do_reset();
    step("R10", 0, 0, 0, 0, 0, 3, 5, 0);
    step("R10", 0, 0, 0, 0, 0, 3, 127, 0);
    step("R10", 0, 0, 0, 0, 0, 3, 40, 0);
    step("R10", 0, 0, 0, 0, 0, 3, 21, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule